// File: doc/BRIEF.md
# Serial-Loaded Display RAM Interface

This block is the host-facing side of a vacuum fluorescent display controller. An external master drives three wires: an active-low strobe that frames a transfer, a serial clock, and a serial data line. Within one strobe-low window, the first complete byte is a command and every later byte is data. Commands either set an address pointer or pick the addressing mode and the target. The target is display RAM, a 4-bit LED port, or key readback. Data bytes then land in the selected target.

The display RAM holds 22 bytes for an 11-digit, 16-segment display. Digit n uses the even byte 2(n-1) for segments 1 to 8 and the odd byte after it for segments 9 to 16. Within each byte, bits 3:0 are the lower nibble and bits 7:4 the upper nibble. A refresh engine reads the RAM through an asynchronous read port. The LED port drives active-low pins.

The serial pins are brought into the system clock domain through synchronizers. Serial-clock rising edges are detected in that clock domain. The serial clock therefore has to be several system clocks slower than the system clock.

Top module: `vfd_serial_ram`

## Requirements
- R1: The first complete byte after the strobe goes low is a command. Every later complete byte in the same strobe-low window is data.
- R2: Serial data is sampled on each rising edge of the serial clock and shifted in least significant bit first.
- R3: If the strobe goes high before eight bits are in, the partial byte has no effect. The next strobe-low window starts again with a command byte.
- R4: Command encoding uses bits 7:6. `11` loads the address pointer from bits 5:0. `01` is a mode command: bit 2 = 1 selects fixed addressing and 0 selects auto-increment, and bits 1:0 select the target (00 display RAM, 01 LED port, 10 key read, 11 none). Classes `00` and `10` change nothing.
- R5: In auto-increment mode with the display target, the pointer advances after each data byte and goes from 21 (15h) back to 0. When the pointer is above 21, a data byte writes nothing and the pointer goes to 0.
- R6: In fixed mode the pointer does not change on data bytes. Repeated bytes overwrite the same RAM byte.
- R7: `rd_data` returns the RAM byte at `rd_addr` for addresses 0 to 21 and returns 0 for addresses 22 to 31.
- R8: With the LED target, bit k of a data byte drives `led_n[k]` (0 = lit, 1 = dark) for k = 0 to 3. Bits 7:4 are discarded. LED data bytes leave the pointer unchanged.
- R9: After reset, `led_n` is 4'hF, every RAM byte is 0, the pointer is 0, and the mode is auto-increment with the display target.
- R10: With the key-read target or no target, data bytes change neither the RAM nor the LED port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stb | input | 1 | Serial strobe, low frames a transfer |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdin | input | 1 | Serial data in, LSB first |
| rd_addr | input | 5 | Refresh read address |
| rd_data | output | 8 | Refresh read data |
| led_n | output | 4 | LED pins, active low |

## Verification
A wrong pointer or mode register stays hidden until the next data byte. It then shows up as a byte in the wrong RAM location, or as a missing or duplicated write. The read port sweeps all addresses continuously, so such an error appears within one sweep of 32 system clocks after that byte settles. A bit counter left stale by an aborted transfer shifts every later byte by some bits. That scrambles the next command: it points the pointer somewhere unexpected or writes the command byte as data, and both are visible on the read port or `led_n` a few clocks after the byte completes.

// File: rtl/vfdser_pkg.sv
package vfdser_pkg;
    typedef enum logic [1:0] {
        TGT_DISP = 2'b00,
        TGT_LED  = 2'b01,
        TGT_KEY  = 2'b10,
        TGT_NONE = 2'b11
    } tgt_e;

    localparam logic [1:0] CLS_MODE = 2'b01;
    localparam logic [1:0] CLS_ADDR = 2'b11;
endpackage

// File: rtl/vfdser_sync.sv
module vfdser_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/vfdser_shift.sv
module vfdser_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              sclk,
    input  logic              sdin,
    output logic              byte_v,
    output logic              byte_cmd,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int CW = $clog2(BYTE_W);

    typedef struct packed {
        logic              sclk_prev;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] sh;
        logic              first;
        logic              v;
        logic              cmd;
        logic [BYTE_W-1:0] data;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic [BYTE_W-1:0] sh_next;

    always_comb begin
        st_d           = st_q;
        st_d.v         = 1'b0;
        st_d.sclk_prev = sclk;
        sh_next        = {sdin, st_q.sh[BYTE_W-1:1]};
        if (stb) begin
            st_d.cnt   = '0;
            st_d.first = 1'b1;
        end else if (sclk && !st_q.sclk_prev) begin
            st_d.sh  = sh_next;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(BYTE_W - 1)) begin
                st_d.cnt   = '0;
                st_d.v     = 1'b1;
                st_d.cmd   = st_q.first;
                st_d.data  = sh_next;
                st_d.first = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b1;
            st_q.first     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_v    = st_q.v;
    assign byte_cmd  = st_q.cmd;
    assign byte_data = st_q.data;

    // R3: a released strobe never lets a byte complete in the next cycle
    assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !byte_v);
    // R1: a command byte is never immediately followed by another byte strobe
    assert_cmd_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_v && byte_cmd) |=> !byte_v);
endmodule

// File: rtl/vfdser_ram.sv
module vfdser_ram #(
    parameter int DEPTH = 22,
    parameter int RA_W  = 5,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RA_W-1:0] wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [RA_W-1:0] rd_addr,
    output logic [DW-1:0]   rd_data
);
    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_addr == RA_W'(i))) mem_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == RA_W'(i)) rd_data = mem_q[i];
        end
    end

    // R10: RAM contents move only on a write strobe
    assert_ram_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/vfd_serial_ram.sv
module vfd_serial_ram #(
    parameter int DIGITS      = 11,
    parameter int SYNC_STAGES = 2,
    parameter int LED_W       = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          stb,
    input  logic                          sclk,
    input  logic                          sdin,
    input  logic [$clog2(2*DIGITS)-1:0]   rd_addr,
    output logic [7:0]                    rd_data,
    output logic [LED_W-1:0]              led_n
);
    import vfdser_pkg::*;

    localparam int DEPTH = 2 * DIGITS;
    localparam int RA_W  = $clog2(DEPTH);
    localparam int PW    = 6;

    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic             fixed;
        tgt_e             tgt;
        logic [LED_W-1:0] led;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic       s_stb, s_sclk, s_sdin;
    logic       byte_v, byte_cmd;
    logic [7:0] byte_data;
    logic       wr_en;

    vfdser_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({stb, sclk, sdin}),
        .dout ({s_stb, s_sclk, s_sdin})
    );

    vfdser_shift #(.BYTE_W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (s_stb),
        .sclk     (s_sclk),
        .sdin     (s_sdin),
        .byte_v   (byte_v),
        .byte_cmd (byte_cmd),
        .byte_data(byte_data)
    );

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (byte_v) begin
            if (byte_cmd) begin
                unique case (byte_data[7:6])
                    CLS_ADDR: ctl_d.ptr = byte_data[PW-1:0];
                    CLS_MODE: begin
                        ctl_d.fixed = byte_data[2];
                        ctl_d.tgt   = tgt_e'(byte_data[1:0]);
                    end
                    default: ;
                endcase
            end else begin
                unique case (ctl_q.tgt)
                    TGT_DISP: begin
                        wr_en = (ctl_q.ptr < PW'(DEPTH));
                        if (!ctl_q.fixed) begin
                            ctl_d.ptr = (ctl_q.ptr >= PW'(DEPTH - 1)) ? '0
                                                                      : ctl_q.ptr + 1'b1;
                        end
                    end
                    TGT_LED: ctl_d.led = byte_data[LED_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.tgt   <= TGT_DISP;
            ctl_q.led   <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    vfdser_ram #(.DEPTH(DEPTH), .RA_W(RA_W), .DW(8)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(ctl_q.ptr[RA_W-1:0]),
        .wr_data(byte_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    assign led_n = ctl_q.led;

    // R8: LED pins hold unless a byte arrives
    assert_led_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_v |=> $stable(led_n));
    // R5: after an auto-increment display byte the pointer is inside the RAM
    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_v && !byte_cmd && ctl_q.tgt == TGT_DISP && !ctl_q.fixed)
        |=> (ctl_q.ptr < PW'(DEPTH)));
    // R6: data bytes in fixed mode leave the pointer where it was
    assert_fixed_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_v && !byte_cmd && ctl_q.fixed) |=> $stable(ctl_q.ptr));
endmodule

// File: tb/vfd_serial_ram_test.sv
module vfd_serial_ram_test;
    localparam int DEPTH = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b1;
    logic       sclk = 1'b1;
    logic       sdin = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] led_n;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit busy = 1'b1;
    bit sweep_en = 1'b1;
    logic [4:0] probe_addr = '0;

    int m_ram[DEPTH];
    int m_ptr = 0;
    bit m_fixed = 0;
    int m_tgt = 0;
    int m_led = 15;
    bit m_first = 1;

    always #4 clk = ~clk;

    vfd_serial_ram uut (
        .clk(clk), .rst_n(rst_n), .stb(stb), .sclk(sclk), .sdin(sdin),
        .rd_addr(rd_addr), .rd_data(rd_data), .led_n(led_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Cycle-by-cycle comparison against the behavioural model
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            finish_run();
        end
        if (rst_n && !busy) begin
            chk("R8 led_n model", led_n, m_led);
            chk("R7 rd_data model", rd_data, (rd_addr < DEPTH) ? m_ram[rd_addr] : 0);
        end
        rd_addr <= sweep_en ? rd_addr + 5'd1 : probe_addr;
    end

    task automatic apply(input logic [7:0] b);
        if (m_first) begin
            m_first = 0;
            if (b[7:6] == 2'b11) m_ptr = b[5:0];
            else if (b[7:6] == 2'b01) begin
                m_fixed = b[2];
                m_tgt = b[1:0];
            end
        end else if (m_tgt == 0) begin
            if (m_ptr < DEPTH) m_ram[m_ptr] = b;
            if (!m_fixed) m_ptr = (m_ptr >= DEPTH - 1) ? 0 : m_ptr + 1;
        end else if (m_tgt == 1) begin
            m_led = b[3:0];
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sclk = 1'b0;
        sdin = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            if (i == 7) busy = 1'b1;
            send_bit(b[i]);
        end
        repeat (8) @(negedge clk);
        apply(b);
        busy = 1'b0;
    endtask

    task automatic open_frame();
        @(negedge clk);
        stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (4) @(negedge clk);
        stb = 1'b1;
        m_first = 1;
        repeat (8) @(negedge clk);
    endtask

    task automatic probe(input int a, input int exp, input string tag);
        @(negedge clk);
        sweep_en = 1'b0;
        probe_addr = 5'(a);
        repeat (2) @(negedge clk);
        chk(tag, rd_data, exp);
        sweep_en = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_ram[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        busy = 1'b0;

        // R9 reset state
        chk("R9 led_n after reset", led_n, 4'hF);
        probe(0, 0, "R9 ram[0] after reset");
        probe(21, 0, "R9 ram[21] after reset");

        // R1 R2: address command then auto-increment data, LSB first
        open_frame(); send_byte(8'hC0); send_byte(8'h12); send_byte(8'h34);
        send_byte(8'h56); close_frame();
        probe(1, 8'h34, "R2 LSB-first byte at 1");
        probe(2, 8'h56, "R1 third data byte at 2");

        // R5 wrap from 21 to 0
        open_frame(); send_byte(8'hD4); send_byte(8'hA1); send_byte(8'hB2);
        send_byte(8'hC3); close_frame();
        probe(21, 8'hB2, "R5 byte at 21");
        probe(0, 8'hC3, "R5 wrapped byte at 0");

        // R5 pointer above 21: no write, pointer to 0
        open_frame(); send_byte(8'hE0); send_byte(8'h77); send_byte(8'h88);
        close_frame();
        probe(0, 8'h88, "R5 out-of-range then 0");

        // R6 fixed addressing
        open_frame(); send_byte(8'h44); close_frame();
        open_frame(); send_byte(8'hC5); send_byte(8'h11); send_byte(8'h22);
        send_byte(8'h33); close_frame();
        probe(5, 8'h33, "R6 fixed overwrite at 5");
        probe(6, 0, "R6 neighbour untouched");

        // R8 LED port
        open_frame(); send_byte(8'h41); send_byte(8'hA5); close_frame();
        chk("R8 led_n low nibble", led_n, 4'h5);
        open_frame(); send_byte(8'h41); send_byte(8'hF0); close_frame();
        chk("R8 led_n upper bits discarded", led_n, 4'h0);
        open_frame(); send_byte(8'h40); send_byte(8'h99); close_frame();
        probe(5, 8'h99, "R8 pointer unchanged by LED writes");

        // R10 key-read target ignores data
        open_frame(); send_byte(8'h42); send_byte(8'hFF); send_byte(8'h00);
        close_frame();
        probe(6, 0, "R10 key target no RAM write");
        chk("R10 key target LED unchanged", led_n, 4'h0);

        // R3 abort mid-byte, then new window starts with a command
        open_frame(); send_byte(8'h40); close_frame();
        open_frame(); send_byte(8'hC8);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        close_frame();
        open_frame(); send_byte(8'h40); send_byte(8'h5A); close_frame();
        probe(8, 8'h5A, "R3 partial byte discarded");
        probe(9, 0, "R3 command not taken as data");

        // R4 ignored command class
        open_frame(); send_byte(8'h80); send_byte(8'h66); close_frame();
        probe(9, 8'h66, "R4 class 10 changes nothing");

        // R7 out-of-range read
        probe(30, 0, "R7 read above RAM");

        repeat (40) @(negedge clk);
        finish_run();
    end
endmodule